// File: doc/BRIEF.md
# Fuse Word Programming Sequencer

This block blows bits of one 32-bit word of a one-time-programmable fuse array. A register front end gives it a one-cycle start pulse together with a word index, the data to burn and a packed timing word. The engine first senses the word already stored at that index. It drops every bit that is already blown from the data, and then walks the masked word from bit 0 upwards, shifting it right with zero fill. Each 1 gets a program strobe followed by a relax gap. Each 0 is passed over in a single cycle. When all bits have been visited it pulses done, and then enforces a fixed postamble. During the postamble it refuses new work, so that the fuse cells can settle.

A parameter selects a banked variant. In that variant the front end presents four data lanes. Word index bits [1:0] pick the slot inside a four-word bank (index / 4 is the bank), and only the lane for that slot is burned into the indexed word. The banked variant also decodes the timing word with a different layout. The fuse array is a behavioural model inside the block. A peek port reads any word of it combinationally for observation.

Top module: `fuse_prog_seq`

## Requirements
- R1: During and straight after reset, busy_o, done_o, holdoff_o and strobe_o are low, and every fuse word reads as zero through the peek port.
- R2: After an operation the addressed word equals its old contents OR the programmed data. A blown bit never returns to 0.
- R3: In flat mode (BANKED=0) the timing word is decoded as strobe length = bits [11:0], relax length = bits [15:12] and sense length = bits [21:16]; bits [31:22] are ignored. A field value v gives a phase of v+1 cycles.
- R4: Bits that are 0 in the data, or already 1 in the fuse, cost one cycle each and raise no strobe. Every other bit costs 1 + (strobe+1) + (relax+1) cycles, of which strobe+1 cycles have strobe_o high. done_o rises sense+1+sum(bit costs) clock edges after the edge that samples start_i.
- R5: done_o is high for exactly one cycle. The new word value is visible on the peek port in the cycle after done_o.
- R6: After done_o, holdoff_o is high for exactly POST_CYC cycles. A start_i that arrives while busy_o or holdoff_o is high is ignored: it programs nothing and does not change the timing of the running operation.
- R7: In banked mode (BANKED=1) the strobe length is bits [11:0] and the source-setup length is bits [19:12]; bits [31:20] are ignored. The setup length sets both the sense phase and the gap after each blown bit.
- R8: In banked mode, lane addr_i[1:0] of data_i (lane k occupies bits [32k+31:32k]) is burned into word addr_i. The other lanes and the other words of the bank are left untouched.
- R9: The address, the data and the timing are captured on the start cycle. Later changes to these inputs do not affect the operation in flight.
- R10: strobe_o is high only while busy_o is high, and busy_o and holdoff_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to program a word |
| addr_i | input | 6 | Fuse word index |
| data_i | input | 32 (128 when banked) | Data lanes to burn |
| timing_i | input | 32 | Packed phase lengths |
| peek_addr_i | input | 6 | Observation read address |
| peek_data_o | output | 32 | Fuse word at peek_addr_i |
| busy_o | output | 1 | Operation in progress, up to and including the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| holdoff_o | output | 1 | Postamble in progress |
| strobe_o | output | 1 | Program strobe to the fuse cell |

## Verification
The assertions assume a few things about the inputs. The peek address is treated as a plain observation input: the monotonic-fuse property only compares data across cycles in which that address stayed the same. The assertions also assume that start_i is a level sampled on clock edges, so that a start during the postamble can be related to busy_o in the next cycle. The stimulus meets these assumptions. It changes every input half a cycle away from the active edge and keeps the peek address fixed for the whole of an operation. Phase fields are kept small so that each operation finishes in a few hundred cycles.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_SCAN, ST_STROBE, ST_RELAX, ST_DONE, ST_HOLD
  } seq_state_e;
endpackage

// File: rtl/fps_timing.sv
module fps_timing #(
  parameter bit BANKED = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  logic [31:0] timing_i,
  output logic [7:0]  read_len_o,
  output logic [11:0] strobe_len_o,
  output logic [7:0]  relax_len_o
);
  logic [7:0] rd_n, rx_n;
  logic       unused_hi;

  generate
    if (BANKED) begin : g_bank
      // one setup field drives both the sense phase and the post-bit gap
      assign rd_n      = timing_i[19:12];
      assign rx_n      = timing_i[19:12];
      assign unused_hi = ^timing_i[31:20];
    end else begin : g_flat
      assign rd_n      = {2'b00, timing_i[21:16]};
      assign rx_n      = {4'b0000, timing_i[15:12]};
      assign unused_hi = ^timing_i[31:22];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      read_len_o   <= '0;
      strobe_len_o <= '0;
      relax_len_o  <= '0;
    end else if (load_i) begin
      read_len_o   <= rd_n;
      strobe_len_o <= timing_i[11:0];
      relax_len_o  <= rx_n;
    end
  end
endmodule

// File: rtl/fps_fuse_array.sv
module fps_fuse_array #(
  parameter int WORDS  = 64,
  parameter int DATA_W = 32,
  parameter int AW     = $clog2(WORDS),
  parameter int BW     = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     sense_addr_i,
  output logic [DATA_W-1:0] sense_data_o,
  input  logic [AW-1:0]     peek_addr_i,
  output logic [DATA_W-1:0] peek_data_o,
  input  logic              blow_en_i,
  input  logic [AW-1:0]     blow_addr_i,
  input  logic [BW-1:0]     blow_bit_i
);
  logic [DATA_W-1:0] cells [WORDS];

  assign sense_data_o = cells[sense_addr_i];
  assign peek_data_o  = cells[peek_addr_i];

  // behavioural model: reset stands for a virgin array, bits only set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) cells[w] <= '0;
    end else if (blow_en_i) begin
      cells[blow_addr_i][blow_bit_i] <= 1'b1;
    end
  end
endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq
  import fps_pkg::*;
#(
  parameter int WORDS    = 64,
  parameter int DATA_W   = 32,
  parameter int POST_CYC = 250,
  parameter bit BANKED   = 1'b0,
  localparam int AW      = $clog2(WORDS),
  localparam int LANES   = BANKED ? 4 : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [LANES*DATA_W-1:0] data_i,
  input  logic [31:0]             timing_i,
  input  logic [AW-1:0]           peek_addr_i,
  output logic [DATA_W-1:0]       peek_data_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    holdoff_o,
  output logic                    strobe_o
);
  localparam int BW   = $clog2(DATA_W);
  localparam int PC_W = $clog2(POST_CYC + 1);

  seq_state_e        state;
  logic [11:0]       cnt;
  logic [AW-1:0]     op_addr;
  logic [DATA_W-1:0] shreg;
  logic [BW-1:0]     bitidx;
  logic [PC_W-1:0]   hold_cnt;
  logic [DATA_W-1:0] lane, sense_data;
  logic [7:0]        read_len, relax_len;
  logic [11:0]       strobe_len;
  logic              accept, blow_en, last_bit;

  generate
    if (BANKED) begin : g_lane
      assign lane = data_i[addr_i[1:0]*DATA_W +: DATA_W];
    end else begin : g_single
      assign lane = data_i;
    end
  endgenerate

  assign accept   = (state == ST_IDLE) && start_i;
  assign blow_en  = (state == ST_STROBE) && (cnt == strobe_len);
  assign last_bit = (bitidx == BW'(DATA_W - 1));

  fps_timing #(.BANKED(BANKED)) u_tim (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .timing_i(timing_i),
    .read_len_o(read_len), .strobe_len_o(strobe_len), .relax_len_o(relax_len)
  );

  fps_fuse_array #(.WORDS(WORDS), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .sense_addr_i(op_addr), .sense_data_o(sense_data),
    .peek_addr_i(peek_addr_i), .peek_data_o(peek_data_o),
    .blow_en_i(blow_en), .blow_addr_i(op_addr), .blow_bit_i(bitidx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      op_addr  <= '0;
      shreg    <= '0;
      bitidx   <= '0;
      hold_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_i) begin
          op_addr <= addr_i;
          shreg   <= lane;
          cnt     <= '0;
          state   <= ST_READ;
        end
        ST_READ: if (cnt == {4'd0, read_len}) begin
          cnt    <= '0;
          shreg  <= shreg & ~sense_data;   // never strike a blown cell again
          bitidx <= '0;
          state  <= ST_SCAN;
        end else cnt <= cnt + 1'b1;
        ST_SCAN: if (shreg[0]) begin
          cnt   <= '0;
          state <= ST_STROBE;
        end else begin
          shreg  <= shreg >> 1;
          bitidx <= bitidx + 1'b1;
          if (last_bit) state <= ST_DONE;
        end
        ST_STROBE: if (cnt == strobe_len) begin
          cnt   <= '0;
          state <= ST_RELAX;
        end else cnt <= cnt + 1'b1;
        ST_RELAX: if (cnt == {4'd0, relax_len}) begin
          cnt    <= '0;
          shreg  <= shreg >> 1;
          bitidx <= bitidx + 1'b1;
          state  <= last_bit ? ST_DONE : ST_SCAN;
        end else cnt <= cnt + 1'b1;
        ST_DONE: begin
          hold_cnt <= '0;
          state    <= ST_HOLD;
        end
        ST_HOLD: if (hold_cnt == PC_W'(POST_CYC - 1)) state <= ST_IDLE;
                 else hold_cnt <= hold_cnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state != ST_IDLE) && (state != ST_HOLD);
  assign done_o    = (state == ST_DONE);
  assign holdoff_o = (state == ST_HOLD);
  assign strobe_o  = (state == ST_STROBE);
endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
  parameter int DATA_W = 32,
  parameter int AW     = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [AW-1:0]     peek_addr_i,
  input logic [DATA_W-1:0] peek_data_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              holdoff_o,
  input logic              strobe_o
);
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_hold_follows_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> holdoff_o);

  assert_start_in_hold_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (holdoff_o && start_i) |=> !busy_o);

  assert_strobe_inside_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> busy_o);

  assert_busy_hold_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && holdoff_o));

  assert_fuse_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(peek_addr_i) |-> ((peek_data_o & $past(peek_data_o)) == $past(peek_data_o)));
endmodule

bind fuse_prog_seq fps_checker #(.DATA_W(DATA_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .peek_addr_i(peek_addr_i), .peek_data_o(peek_data_o),
  .busy_o(busy_o), .done_o(done_o), .holdoff_o(holdoff_o), .strobe_o(strobe_o)
);

// File: tb/sim_fuse_prog_seq.sv
module sim_fuse_prog_seq;
  localparam int POST = 250;
  localparam int NV   = 6;
  // stimulus: address, data, timing; expected: programmed-bit count, final word
  localparam logic [5:0]  V_AD [NV] = '{6'd3, 6'd3, 6'd63, 6'd0, 6'd17, 6'd17};
  localparam logic [31:0] V_DT [NV] = '{32'h0000_00A5, 32'h0000_0F0F, 32'h8000_0001,
                                        32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
  localparam logic [31:0] V_TM [NV] = '{32'h0002_1003, 32'h0001_2002, 32'hFFC0_0000,
                                        32'h003F_F005, 32'h0000_1001, 32'h0003_0000};
  localparam int          V_NB [NV] = '{4, 6, 2, 0, 32, 0};
  localparam logic [31:0] V_EX [NV] = '{32'h0000_00A5, 32'h0000_0FAF, 32'h8000_0001,
                                        32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF};

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic a_start = 0, b_start = 0;
  logic [5:0] a_addr = 0, b_addr = 0, a_peek = 0, b_peek = 0;
  logic [31:0] a_data = 0, a_tim = 0, b_tim = 0;
  logic [127:0] b_data = 0;
  logic [31:0] a_pd, b_pd;
  logic a_busy, a_done, a_hold, a_strb, b_busy, b_done, b_hold, b_strb;

  fuse_prog_seq #(.POST_CYC(POST)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(a_start), .addr_i(a_addr), .data_i(a_data),
    .timing_i(a_tim), .peek_addr_i(a_peek), .peek_data_o(a_pd), .busy_o(a_busy),
    .done_o(a_done), .holdoff_o(a_hold), .strobe_o(a_strb));

  fuse_prog_seq #(.POST_CYC(POST), .BANKED(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .start_i(b_start), .addr_i(b_addr), .data_i(b_data),
    .timing_i(b_tim), .peek_addr_i(b_peek), .peek_data_o(b_pd), .busy_o(b_busy),
    .done_o(b_done), .holdoff_o(b_hold), .strobe_o(b_strb));

  bit cur = 0;
  logic s_busy, s_done, s_hold, s_strb;
  logic [31:0] s_pd;
  assign s_busy = cur ? b_busy : a_busy;
  assign s_done = cur ? b_done : a_done;
  assign s_hold = cur ? b_hold : a_hold;
  assign s_strb = cur ? b_strb : a_strb;
  assign s_pd   = cur ? b_pd   : a_pd;

  logic [31:0] mir0 [64], mir1 [64];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic int exp_lat(input bit bk, input logic [31:0] t, input logic [31:0] m);
    int rd, s, r, l;
    s = int'(t[11:0]);
    if (bk) begin rd = int'(t[19:12]); r = rd; end
    else begin rd = int'(t[21:16]); r = int'(t[15:12]); end
    l = rd + 1;
    for (int i = 0; i < 32; i++) l += m[i] ? (3 + s + r) : 1;
    return l;
  endfunction

  task automatic drive(input logic st, input logic [5:0] ad, input logic [127:0] ln,
                       input logic [31:0] t);
    if (cur) begin b_start = st; b_addr = ad; b_data = ln; b_tim = t; end
    else begin a_start = st; a_addr = ad; a_data = ln[31:0]; a_tim = t; end
  endtask

  task automatic set_peek(input logic [5:0] ad);
    if (cur) b_peek = ad; else a_peek = ad;
  endtask

  // poke: 0 none, 1 foreign start while busy, 2 foreign start during holdoff
  task automatic do_op(input logic [5:0] ad, input logic [127:0] ln, input logic [31:0] t,
                       input logic [31:0] prog, input int poke, input string rq);
    logic [31:0] old, m;
    int n, sc, hc;
    bit got;
    old = cur ? mir1[ad] : mir0[ad];
    m = prog & ~old;
    @(negedge clk);
    set_peek(ad);
    drive(1'b1, ad, ln, t);
    @(posedge clk); #1;
    drive(1'b0, ad, ln, t);
    n = 0; sc = 0; got = 0;
    while (!got && n < 5000) begin
      @(posedge clk); #1;
      n++;
      if (s_strb) sc++;
      if (s_done) got = 1;
      if (poke == 1 && n == 4) drive(1'b1, 6'd40, {4{32'hFFFF_FFFF}}, 32'h0);
      if (poke == 1 && n == 5) drive(1'b0, 6'd40, {4{32'hFFFF_FFFF}}, 32'h0);
    end
    check(got, rq, "done seen", got, 1);
    check(n == exp_lat(cur, t, m), rq, "latency", n, exp_lat(cur, t, m));
    check(sc == $countones(m) * (int'(t[11:0]) + 1), "R4", "strobe cycles",
          sc, $countones(m) * (int'(t[11:0]) + 1));
    @(posedge clk); #1;
    check(!s_done, "R5", "done width", s_done, 0);
    check(s_pd == (old | prog), "R2", "word after done", s_pd, old | prog);
    hc = 0;
    while (s_hold && hc < 1000) begin
      hc++;
      if (poke == 2 && hc == 3) drive(1'b1, 6'd40, {4{32'hFFFF_FFFF}}, 32'h0);
      if (poke == 2 && hc == 4) drive(1'b0, 6'd40, {4{32'hFFFF_FFFF}}, 32'h0);
      @(posedge clk); #1;
    end
    check(hc == POST, "R6", "holdoff cycles", hc, POST);
    check(!s_busy, "R6", "idle after holdoff", s_busy, 0);
    if (cur) mir1[ad] = old | prog; else mir0[ad] = old | prog;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] ln;
    logic [5:0] ad;
    for (int w = 0; w < 64; w++) begin mir0[w] = '0; mir1[w] = '0; end
    repeat (3) @(posedge clk); #1;
    // R1: outputs and array during reset
    check(!a_busy && !a_done && !a_hold && !a_strb, "R1", "u0 flags in reset",
          {a_busy, a_done, a_hold, a_strb}, 0);
    a_peek = 6'd3; b_peek = 6'd63; #1;
    check(a_pd == 0 && b_pd == 0, "R1", "virgin array", a_pd | b_pd, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check(!b_busy && !b_done && !b_hold && !b_strb, "R1", "u1 flags after reset",
          {b_busy, b_done, b_hold, b_strb}, 0);

    // R2/R3/R4: table of flat-mode vectors
    cur = 0;
    for (int v = 0; v < NV; v++) begin
      check($countones(V_DT[v] & ~mir0[V_AD[v]]) == V_NB[v], "R4", "table bit count",
            $countones(V_DT[v] & ~mir0[V_AD[v]]), V_NB[v]);
      do_op(V_AD[v], {96'b0, V_DT[v]}, V_TM[v], V_DT[v], 0, "R3");
      check(mir0[V_AD[v]] == V_EX[v], "R2", "table final word", mir0[V_AD[v]], V_EX[v]);
    end

    // R9 and R6: foreign start and input changes while busy
    do_op(6'd5, {96'b0, 32'h0000_0003}, 32'h0002_2002, 32'h0000_0003, 1, "R9");
    @(negedge clk); a_peek = 6'd40; #1;
    check(a_pd == 32'h0, "R6", "word 40 after busy start", a_pd, 0);

    // R6: foreign start during holdoff
    do_op(6'd7, {96'b0, 32'h0000_0010}, 32'h0000_0000, 32'h0000_0010, 2, "R6");
    @(negedge clk); a_peek = 6'd40; #1;
    check(a_pd == 32'h0, "R6", "word 40 after holdoff start", a_pd, 0);

    // R7/R8: banked instance
    cur = 1;
    ln = {32'hAAAA_0000, 32'h5555_0000, 32'h0000_C003, 32'hFFFF_FFFF};
    do_op(6'd9, ln, 32'h00F0_3002, ln[32 +: 32], 0, "R7");
    for (int k = 8; k < 12; k++) begin
      if (k != 9) begin
        @(negedge clk); b_peek = 6'(k); #1;
        check(b_pd == 32'h0, "R8", "bank neighbour untouched", b_pd, 0);
      end
    end
    ln = {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0100};
    do_op(6'd12, ln, 32'h0000_0000, ln[31:0], 0, "R8");
    @(negedge clk); b_peek = 6'd13; #1;
    check(b_pd == 32'h0, "R8", "slot1 not written from lane0 op", b_pd, 0);
    ad = 6'd63;
    ln = {32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
    do_op(ad, ln, 32'h0000_1000, ln[96 +: 32], 0, "R7");
    @(negedge clk); b_peek = 6'd62; #1;
    check(b_pd == 32'h0, "R8", "slot2 untouched", b_pd, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule